// File: doc/BRIEF.md
# Configurable Dual-Port SRAM Block

This block holds 256 bits of storage behind one write port and one read port. Each port has its own clock, and the two clocks may be unrelated. A static organisation input selects the shape of the array. With it high, the array is 32 words of 8 bits. With it low, the same bits form 64 words of 4 bits, and each word is one half of a byte row.

Each port registers its address, data and enables on its active clock edge, and only then touches the array. Each port also has a clock-invert input that moves its active edge from the rising edge to the falling edge. A write takes place only when both the write enable and the block enable are high. The block enable lets several blocks share one write bus, with a decoder picking one of them. The read result is registered and is updated only by enabled reads.

Top module: `dpsram_cfg`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first enabled read, `rd_data` is 0.
- R2: When `byte_mode`=1, addresses are 6 bits wide but only bits 4:0 pick one of 32 byte rows. Bit 5 is ignored on both ports, and all 8 data bits are written and read.
- R3: When `byte_mode`=0, address bits 5:1 pick the byte row and bit 0 picks a nibble: 0 is bits 3:0 and 1 is bits 7:4. A write replaces only that nibble with `wr_data[3:0]`, and the other nibble of the row keeps its value.
- R4: When `byte_mode`=0, a read returns the selected nibble on `rd_data[3:0]` with `rd_data[7:4]` = 0, and `wr_data[7:4]` has no effect.
- R5: The array changes only when `wr_en` and `blk_en` are both 1 at a write edge. With either of them at 0, the contents stay the same.
- R6: When `rd_en` is low at a read edge, `rd_data` keeps its previous value, even if `rd_addr` changes.
- R7: An enabled read presented before read edge k appears on `rd_data` after read edge k+1 and not earlier. A write presented before write edge k is stored at edge k+1.
- R8: With both ports on one clock, a read and a write presented together to the same location return the old contents. A read issued one edge later returns the new data.
- R9: With `wr_clk_inv`/`rd_clk_inv` = 1, the port acts on the falling edge of its clock and ignores rising edges.
- R10: Writes on `wr_clk` are readable through `rd_clk` when the two clocks run at unrelated frequencies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset of the port registers |
| byte_mode | input | 1 | Static organisation: 1 = 32x8, 0 = 64x4 |
| wr_clk | input | 1 | Write port clock |
| wr_clk_inv | input | 1 | 1 selects the falling edge of `wr_clk` |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_en | input | 1 | Write enable |
| blk_en | input | 1 | Block select; qualifies writes |
| rd_clk | input | 1 | Read port clock |
| rd_clk_inv | input | 1 | 1 selects the falling edge of `rd_clk` |
| rd_addr | input | ADDR_W | Read address |
| rd_en | input | 1 | Read enable |
| rd_data | output | DATA_W | Registered read data |

## Verification
The bench builds the block with its default parameters: a 6-bit address and 8-bit data, which gives the full 256-bit array. These values make the ignored top address bit in byte mode reachable. They also let a byte row be written in nibble mode and read back in byte mode, which shows where each nibble lands. Over the run, the bench moves the read clock between the shared 200 MHz clock and an unrelated slower one, and it drives both clock-invert inputs high. This covers same-clock collisions, cross-clock transfers and falling-edge operation.

// File: rtl/dpsram_cfg.sv
module dpsram_cfg #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              wr_clk,
  input  logic              wr_clk_inv,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              blk_en,
  input  logic              rd_clk,
  input  logic              rd_clk_inv,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data
);
  localparam int ROW_W = ADDR_W - 1;
  localparam int ROWS  = 1 << ROW_W;
  localparam int NIB_W = DATA_W / 2;

  logic wck, rck;
  assign wck = wr_clk ^ wr_clk_inv;
  assign rck = rd_clk ^ rd_clk_inv;

  logic [DATA_W-1:0] mem [ROWS];

  logic [ADDR_W-1:0] wa_q, ra_q;
  logic [DATA_W-1:0] wd_q, rd_q;
  logic              we_q, re_q;

  always_ff @(posedge wck or negedge rst_n) begin
    if (!rst_n) begin
      wa_q <= '0;
      wd_q <= '0;
      we_q <= 1'b0;
    end else begin
      wa_q <= wr_addr;
      wd_q <= wr_data;
      we_q <= wr_en & blk_en;
    end
  end

  logic [ROW_W-1:0] w_row, r_row;
  assign w_row = byte_mode ? wa_q[ROW_W-1:0] : wa_q[ADDR_W-1:1];
  assign r_row = byte_mode ? ra_q[ROW_W-1:0] : ra_q[ADDR_W-1:1];

  always_ff @(posedge wck) begin
    if (we_q) begin
      if (byte_mode)
        mem[w_row] <= wd_q;
      else if (wa_q[0])
        mem[w_row][DATA_W-1:NIB_W] <= wd_q[NIB_W-1:0];
      else
        mem[w_row][NIB_W-1:0] <= wd_q[NIB_W-1:0];
    end
  end

  logic [DATA_W-1:0] r_word, r_val;
  logic [NIB_W-1:0]  r_nib;
  assign r_word = mem[r_row];
  assign r_nib  = ra_q[0] ? r_word[DATA_W-1:NIB_W] : r_word[NIB_W-1:0];
  assign r_val  = byte_mode ? r_word : {{(DATA_W-NIB_W){1'b0}}, r_nib};

  always_ff @(posedge rck or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= '0;
      re_q <= 1'b0;
      rd_q <= '0;
    end else begin
      ra_q <= rd_addr;
      re_q <= rd_en;
      if (re_q) rd_q <= r_val;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/dpsram_cfg_chk.sv
module dpsram_cfg_chk #(
  parameter int DATA_W = 8
) (
  input logic              rst_n,
  input logic              byte_mode,
  input logic              wr_clk,
  input logic              wr_clk_inv,
  input logic              wr_en,
  input logic              blk_en,
  input logic              rd_clk,
  input logic              rd_clk_inv,
  input logic              we_q,
  input logic              re_q,
  input logic [DATA_W-1:0] rd_data
);
  logic wck, rck;
  assign wck = wr_clk ^ wr_clk_inv;
  assign rck = rd_clk ^ rd_clk_inv;

  a_r1_reset_clear: assert property (@(posedge rck) disable iff (!rst_n)
    $rose(rst_n) |-> rd_data == '0);

  a_r4_upper_zero: assert property (@(posedge rck) disable iff (!rst_n)
    (!byte_mode && re_q) |=> (byte_mode || rd_data[DATA_W-1:DATA_W/2] == '0));

  a_r5_write_gated: assert property (@(posedge wck) disable iff (!rst_n)
    !(wr_en && blk_en) |=> !we_q);

  a_r6_hold_idle: assert property (@(posedge rck) disable iff (!rst_n)
    !re_q |=> $stable(rd_data));
endmodule

bind dpsram_cfg dpsram_cfg_chk #(.DATA_W(DATA_W)) u_chk (
  .rst_n(rst_n), .byte_mode(byte_mode),
  .wr_clk(wr_clk), .wr_clk_inv(wr_clk_inv), .wr_en(wr_en), .blk_en(blk_en),
  .rd_clk(rd_clk), .rd_clk_inv(rd_clk_inv),
  .we_q(we_q), .re_q(re_q), .rd_data(rd_data)
);

// File: tb/tb_dpsram_cfg.sv
`timescale 1ns/100ps
module tb_dpsram_cfg;
  logic clk = 0, aclk = 0, use_async = 0;
  logic rst_n = 0, byte_mode = 1;
  logic wr_clk_inv = 0, rd_clk_inv = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic wr_en = 0, blk_en = 0, rd_en = 0;
  logic [7:0] rd_data;
  logic wr_clk, rd_clk, wck, rck;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  always #3.5 aclk = ~aclk;
  assign wr_clk = clk;
  assign rd_clk = use_async ? aclk : clk;
  assign wck = wr_clk ^ wr_clk_inv;
  assign rck = rd_clk ^ rd_clk_inv;

  dpsram_cfg dut (
    .rst_n(rst_n), .byte_mode(byte_mode),
    .wr_clk(wr_clk), .wr_clk_inv(wr_clk_inv), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_en(wr_en), .blk_en(blk_en),
    .rd_clk(rd_clk), .rd_clk_inv(rd_clk_inv), .rd_addr(rd_addr),
    .rd_en(rd_en), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d, input logic we, input logic be);
    @(posedge wck); #1;
    wr_addr = a; wr_data = d; wr_en = we; blk_en = be;
    @(posedge wck); #1;
    wr_en = 0; blk_en = 0;
    @(posedge wck); #1;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(posedge rck); #1;
    rd_addr = a; rd_en = 1;
    @(posedge rck); #1;
    rd_en = 0;
    @(posedge rck); #1;
    d = rd_data;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1 chk("R1 during reset", rd_data, 8'h00);
    rst_n = 1;
    repeat (2) @(posedge clk);
    #1 chk("R1 after release", rd_data, 8'h00);
  endtask

  task automatic t_byte_mode();
    logic [7:0] v;
    byte_mode = 1;
    wr(6'h25, 8'hA5, 1, 1);
    rd(6'h05, v); chk("R2 addr bit5 ignored on write", v, 8'hA5);
    wr(6'h03, 8'h3C, 1, 1);
    rd(6'h23, v); chk("R2 addr bit5 ignored on read", v, 8'h3C);
  endtask

  task automatic t_nibble_mode();
    logic [7:0] v;
    byte_mode = 0;
    wr(6'd4, 8'hF7, 1, 1);
    wr(6'd5, 8'h69, 1, 1);
    rd(6'd4, v); chk("R4 low nibble, upper zero", v, 8'h07);
    rd(6'd5, v); chk("R4 high nibble, wr_data[7:4] ignored", v, 8'h09);
    byte_mode = 1;
    rd(6'd2, v); chk("R3 nibble placement in row", v, 8'h97);
    byte_mode = 0;
    wr(6'd4, 8'h0E, 1, 1);
    byte_mode = 1;
    rd(6'd2, v); chk("R3 other nibble preserved", v, 8'h9E);
  endtask

  task automatic t_gating();
    logic [7:0] v;
    byte_mode = 1;
    wr(6'd12, 8'h44, 1, 1);
    wr(6'd12, 8'h99, 1, 0);
    rd(6'd12, v); chk("R5 blk_en low blocks write", v, 8'h44);
    wr(6'd12, 8'h77, 0, 1);
    rd(6'd12, v); chk("R5 wr_en low blocks write", v, 8'h44);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    rd(6'd2, v);
    rd_addr = 6'd12;
    repeat (4) @(posedge rck);
    #1 chk("R6 hold while rd_en low", rd_data, 8'h9E);
  endtask

  task automatic t_latency();
    wr(6'd7, 8'h11, 1, 1);
    @(posedge rck); #1;
    rd_addr = 6'd7; rd_en = 1;
    @(posedge rck); #1;
    rd_en = 0;
    chk("R7 not visible after one edge", rd_data, 8'h9E);
    @(posedge rck); #1;
    chk("R7 visible after two edges", rd_data, 8'h11);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    wr(6'd20, 8'h10, 1, 1);
    @(posedge clk); #1;
    wr_addr = 6'd20; wr_data = 8'h20; wr_en = 1; blk_en = 1;
    rd_addr = 6'd20; rd_en = 1;
    @(posedge clk); #1;
    wr_en = 0; blk_en = 0; rd_en = 0;
    @(posedge clk); #1;
    chk("R8 same-cycle read returns old", rd_data, 8'h10);
    rd(6'd20, v); chk("R8 later read returns new", v, 8'h20);
  endtask

  task automatic t_polarity();
    logic [7:0] v;
    wr_clk_inv = 1; rd_clk_inv = 1;
    repeat (2) @(posedge clk);
    wr(6'd30, 8'hC3, 1, 1);
    rd(6'd30, v); chk("R9 inverted clocks round trip", v, 8'hC3);
    wr(6'd31, 8'h5E, 1, 1);
    @(negedge clk); #1;
    rd_addr = 6'd31; rd_en = 1;
    @(negedge clk); #1;
    rd_en = 0;
    @(posedge clk); #1;
    chk("R9 rising edge ignored", rd_data, 8'hC3);
    @(negedge clk); #1;
    chk("R9 falling edge loads", rd_data, 8'h5E);
    wr_clk_inv = 0; rd_clk_inv = 0;
    repeat (2) @(posedge clk);
  endtask

  task automatic t_async();
    logic [7:0] v;
    use_async = 1;
    repeat (3) @(posedge aclk);
    wr(6'd9, 8'h5A, 1, 1);
    rd(6'd9, v); chk("R10 cross-clock read", v, 8'h5A);
    wr(6'd10, 8'h33, 1, 1);
    rd(6'd10, v); chk("R10 second cross-clock read", v, 8'h33);
    use_async = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_byte_mode();
    t_nibble_mode();
    t_gating();
    t_hold();
    t_latency();
    t_collision();
    t_polarity();
    t_async();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule